// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a character-clocked raster display. A horizontal counter advances once for every cycle in which the character clock enable is high. A vertical counter advances once at the end of every line. From the two counts and a set of programmed boundaries the block derives display enable, horizontal and vertical blanking, and horizontal and vertical sync. Each sync has its own selectable polarity. Two status bits report vertical retrace and display-inactive. A split-screen flag goes high on the programmed compare line, and a 16-bit display start address is presented to the fetch logic.

Software programs the block through an indexed register pair. A write with `sel_i` low loads the index. A write with `sel_i` high stores the data byte into the indexed register. Reads use the same `sel_i` decode. The horizontal total is stored as the character count minus five, the display end as the count minus one, and the vertical total as the line count minus two. The 10-bit vertical values keep their upper bits in a shared overflow register at index 7. One control bit write-protects indices 0 to 7.

Top module: `crt_timing`

## Requirements
- R1: The horizontal counter starts at 0 and advances only in cycles where `char_en_i` is high. It returns to 0 after reaching (index 0) + 4, so a line is (index 0) + 5 characters long.
- R2: `display_en_o` is high exactly when the horizontal count is at most index 1 and the vertical line is at most the 10-bit display end. The display end is {index 7 bit 6, index 7 bit 1, index 18}.
- R3: `hblank_o` goes high on the character equal to index 2. It goes low on the first later character whose low 6 bits equal {index 5 bit 7, index 3 bits 4:0}.
- R4: Horizontal retrace begins on the character equal to index 4 and ends on the first later character whose low 5 bits equal index 5 bits 4:0. `status_o` bit 0 is the inverse of `display_en_o`.
- R5: The vertical counter advances when the horizontal counter wraps. It returns to 0 after line {index 7 bit 5, index 7 bit 0, index 6} + 1.
- R6: `vblank_o` goes high on the line equal to {index 7 bit 3, index 21}. It goes low on the first later line whose low 8 bits equal index 22.
- R7: Vertical retrace begins on the line {index 7 bit 7, index 7 bit 2, index 16}. It ends on the first later line whose low 4 bits equal index 17 bits 3:0. `status_o` bit 3 shows vertical retrace, and all other status bits read 0.
- R8: Index 25 bit 6 inverts `hsync_o` and index 25 bit 7 inverts `vsync_o`. When a bit is 0, its sync output is high during retrace.
- R9: While index 17 bit 7 is set, data writes to indices 0 to 7 are ignored. Writes to any index above 25 are always ignored.
- R10: `split_o` is high while the current line equals {index 7 bit 4, index 24}.
- R11: `start_addr_o` is {index 12, index 13}.
- R12: After reset, all registers, the index and both counters are 0, and all four blank and retrace flags are low.
- R13: With `sel_i` low, `rdata_o` returns the index in its low 5 bits. With `sel_i` high, it returns the indexed register, which reads as 0 for indices above 25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_en_i | input | 1 | Character clock enable |
| we_i | input | 1 | Register write strobe |
| sel_i | input | 1 | 0 selects the index register, 1 selects the data register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| display_en_o | output | 1 | Active display area |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| status_o | output | 8 | Bit 3 vertical retrace, bit 0 display inactive |
| start_addr_o | output | 16 | Display start address |
| split_o | output | 1 | Line-compare split flag |

## Verification
The bench builds the block with the package defaults: an 8-bit bus, a 5-bit index, 26 registers, a 9-bit horizontal counter and an 11-bit vertical counter. A 16-character line with a frame of about three hundred lines keeps every overflow-supplied bit 8 within a few thousand cycles. An overflow bit 9 is exercised by pushing the display end and retrace start beyond the frame. Randomly gated character enables and random register writes move the counters past lowered totals, so both counters run through their natural wrap.

// File: rtl/crt_timing_pkg.sv
package crt_timing_pkg;
  localparam int DW    = 8;
  localparam int IDX_W = 5;
  localparam int NREG  = 26;
  localparam int NSLOT = 2 ** IDX_W;
  localparam int HCW   = DW + 1;      // holds total + 4
  localparam int VW    = 10;
  localparam int VCW   = VW + 1;      // holds total + 1
  localparam int HBE_W = 6;
  localparam int HSE_W = 5;
  localparam int VBE_W = 8;
  localparam int VSE_W = 4;

  localparam logic [IDX_W-1:0] IX_HTOT = 5'd0;
  localparam logic [IDX_W-1:0] IX_HDE  = 5'd1;
  localparam logic [IDX_W-1:0] IX_HBS  = 5'd2;
  localparam logic [IDX_W-1:0] IX_HBE  = 5'd3;
  localparam logic [IDX_W-1:0] IX_HSS  = 5'd4;
  localparam logic [IDX_W-1:0] IX_HSE  = 5'd5;
  localparam logic [IDX_W-1:0] IX_VTOT = 5'd6;
  localparam logic [IDX_W-1:0] IX_OVF  = 5'd7;
  localparam logic [IDX_W-1:0] IX_SAH  = 5'd12;
  localparam logic [IDX_W-1:0] IX_SAL  = 5'd13;
  localparam logic [IDX_W-1:0] IX_VSS  = 5'd16;
  localparam logic [IDX_W-1:0] IX_VSE  = 5'd17;
  localparam logic [IDX_W-1:0] IX_VDE  = 5'd18;
  localparam logic [IDX_W-1:0] IX_VBS  = 5'd21;
  localparam logic [IDX_W-1:0] IX_VBE  = 5'd22;
  localparam logic [IDX_W-1:0] IX_LCMP = 5'd24;
  localparam logic [IDX_W-1:0] IX_POL  = 5'd25;
  localparam logic [IDX_W-1:0] IX_LAST = IDX_W'(NREG - 1);
  localparam logic [IDX_W-1:0] IX_PROT = 5'd7;

  typedef struct packed {
    logic [DW-1:0]    htotal;
    logic [DW-1:0]    hde;
    logic [DW-1:0]    hbs;
    logic [HBE_W-1:0] hbe;
    logic [DW-1:0]    hss;
    logic [HSE_W-1:0] hse;
    logic [VW-1:0]    vtotal;
    logic [VW-1:0]    vde;
    logic [VW-1:0]    vbs;
    logic [VBE_W-1:0] vbe;
    logic [VW-1:0]    vss;
    logic [VSE_W-1:0] vse;
    logic [VW-1:0]    lcmp;
    logic [2*DW-1:0]  start_addr;
    logic             hpol;
    logic             vpol;
    logic             prot;
  } cfg_t;
endpackage

// File: rtl/crt_regs.sv
module crt_regs
  import crt_timing_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [IDX_W-1:0] idx_o,
  output cfg_t             cfg_o
);
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    regs_q [NSLOT];
  logic             wr_ok;

  assign wr_ok = (idx_q <= IX_LAST) && !(regs_q[IX_VSE][7] && (idx_q <= IX_PROT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      for (int i = 0; i < NSLOT; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      if (!sel_i)     idx_q         <= wdata_i[IDX_W-1:0];
      else if (wr_ok) regs_q[idx_q] <= wdata_i;
    end
  end

  assign rdata_o = sel_i ? regs_q[idx_q] : {{(DW-IDX_W){1'b0}}, idx_q};
  assign idx_o   = idx_q;

  // gather split fields; overflow bit positions are fixed by the register format
  always_comb begin
    cfg_o.htotal     = regs_q[IX_HTOT];
    cfg_o.hde        = regs_q[IX_HDE];
    cfg_o.hbs        = regs_q[IX_HBS];
    cfg_o.hbe        = {regs_q[IX_HSE][7], regs_q[IX_HBE][4:0]};
    cfg_o.hss        = regs_q[IX_HSS];
    cfg_o.hse        = regs_q[IX_HSE][4:0];
    cfg_o.vtotal     = {regs_q[IX_OVF][5], regs_q[IX_OVF][0], regs_q[IX_VTOT]};
    cfg_o.vde        = {regs_q[IX_OVF][6], regs_q[IX_OVF][1], regs_q[IX_VDE]};
    cfg_o.vss        = {regs_q[IX_OVF][7], regs_q[IX_OVF][2], regs_q[IX_VSS]};
    cfg_o.vbs        = {1'b0, regs_q[IX_OVF][3], regs_q[IX_VBS]};
    cfg_o.vbe        = regs_q[IX_VBE];
    cfg_o.vse        = regs_q[IX_VSE][3:0];
    cfg_o.lcmp       = {1'b0, regs_q[IX_OVF][4], regs_q[IX_LCMP]};
    cfg_o.start_addr = {regs_q[IX_SAH], regs_q[IX_SAL]};
    cfg_o.hpol       = regs_q[IX_POL][6];
    cfg_o.vpol       = regs_q[IX_POL][7];
    cfg_o.prot       = regs_q[IX_VSE][7];
  end
endmodule

// File: rtl/crt_counter.sv
module crt_counter #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] next_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         at_last;

  assign at_last = (cnt_q == last_i);
  assign next_o  = at_last ? '0 : cnt_q + W'(1);
  assign wrap_o  = adv_i && at_last;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= next_o;
  end
endmodule

// File: rtl/crt_span_flag.sv
module crt_span_flag #(
  parameter int W  = 9,
  parameter int EW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic [W-1:0]  next_i,
  input  logic [W-1:0]  start_i,
  input  logic [EW-1:0] end_i,
  output logic          flag_o
);
  logic flag_q;

  // start wins; end compares only the low EW bits of the count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (adv_i) begin
      if (next_i == start_i)             flag_q <= 1'b1;
      else if (next_i[EW-1:0] == end_i)  flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/crt_timing.sv
module crt_timing
  import crt_timing_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            char_en_i,
  input  logic            we_i,
  input  logic            sel_i,
  input  logic [7:0]      wdata_i,
  output logic [7:0]      rdata_o,
  output logic            display_en_o,
  output logic            hblank_o,
  output logic            vblank_o,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic [7:0]      status_o,
  output logic [15:0]     start_addr_o,
  output logic            split_o
);
  cfg_t             cfg;
  logic [IDX_W-1:0] idx_q;
  logic [HCW-1:0]   hcnt, hnext, hlast;
  logic [VCW-1:0]   vcnt, vnext, vlast;
  logic             line_tick, frame_tick;
  logic             hret, vret;

  crt_regs u_regs (
    .clk_i, .rst_ni, .we_i, .sel_i, .wdata_i, .rdata_o,
    .idx_o (idx_q),
    .cfg_o (cfg)
  );

  assign hlast = {1'b0, cfg.htotal} + HCW'(4);
  assign vlast = {1'b0, cfg.vtotal} + VCW'(1);

  crt_counter #(.W(HCW)) u_hcnt (
    .clk_i, .rst_ni,
    .adv_i  (char_en_i),
    .last_i (hlast),
    .cnt_o  (hcnt),
    .next_o (hnext),
    .wrap_o (line_tick)
  );

  crt_counter #(.W(VCW)) u_vcnt (
    .clk_i, .rst_ni,
    .adv_i  (line_tick),
    .last_i (vlast),
    .cnt_o  (vcnt),
    .next_o (vnext),
    .wrap_o (frame_tick)
  );

  crt_span_flag #(.W(HCW), .EW(HBE_W)) u_hblank (
    .clk_i, .rst_ni, .adv_i(char_en_i), .next_i(hnext),
    .start_i({1'b0, cfg.hbs}), .end_i(cfg.hbe), .flag_o(hblank_o)
  );

  crt_span_flag #(.W(HCW), .EW(HSE_W)) u_hret (
    .clk_i, .rst_ni, .adv_i(char_en_i), .next_i(hnext),
    .start_i({1'b0, cfg.hss}), .end_i(cfg.hse), .flag_o(hret)
  );

  crt_span_flag #(.W(VCW), .EW(VBE_W)) u_vblank (
    .clk_i, .rst_ni, .adv_i(line_tick), .next_i(vnext),
    .start_i({1'b0, cfg.vbs}), .end_i(cfg.vbe), .flag_o(vblank_o)
  );

  crt_span_flag #(.W(VCW), .EW(VSE_W)) u_vret (
    .clk_i, .rst_ni, .adv_i(line_tick), .next_i(vnext),
    .start_i({1'b0, cfg.vss}), .end_i(cfg.vse), .flag_o(vret)
  );

  assign display_en_o = (hcnt <= {1'b0, cfg.hde}) && (vcnt <= {1'b0, cfg.vde});
  assign hsync_o      = hret ^ cfg.hpol;
  assign vsync_o      = vret ^ cfg.vpol;
  assign status_o     = {4'b0000, vret, 2'b00, ~display_en_o};
  assign start_addr_o = cfg.start_addr;
  assign split_o      = (vcnt == {1'b0, cfg.lcmp});

  logic unused_ok;
  assign unused_ok = frame_tick;
endmodule

// File: rtl/crt_timing_chk.sv
module crt_timing_chk
  import crt_timing_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             char_en_i,
  input logic             we_i,
  input logic             sel_i,
  input logic [IDX_W-1:0] idx_i,
  input logic             prot_i,
  input logic [DW-1:0]    htotal_i,
  input logic             display_en_o,
  input logic             hblank_o,
  input logic             vblank_o,
  input logic             hsync_o,
  input logic             vsync_o,
  input logic             split_o,
  input logic [7:0]       status_o
);
  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!char_en_i && !we_i) |=> ($stable(display_en_o) && $stable(hblank_o) &&
      $stable(vblank_o) && $stable(hsync_o) && $stable(vsync_o) && $stable(split_o)));

  // R3
  hblank_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hblank_o) |-> $past(char_en_i));

  // R7
  vret_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[3]) |-> $past(char_en_i));

  // R2
  disp_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(display_en_o) |-> ($past(char_en_i) || $past(we_i)));

  // R9
  wr_protect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i && prot_i && idx_i == IX_HTOT) |=> $stable(htotal_i));
endmodule

bind crt_timing crt_timing_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .char_en_i    (char_en_i),
  .we_i         (we_i),
  .sel_i        (sel_i),
  .idx_i        (idx_q),
  .prot_i       (cfg.prot),
  .htotal_i     (cfg.htotal),
  .display_en_o (display_en_o),
  .hblank_o     (hblank_o),
  .vblank_o     (vblank_o),
  .hsync_o      (hsync_o),
  .vsync_o      (vsync_o),
  .split_o      (split_o),
  .status_o     (status_o)
);

// File: tb/crt_timing_test.sv
module crt_timing_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        char_en = 1'b0;
  logic        we = 1'b0;
  logic        sel = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        disp, hblank, vblank, hsync, vsync, split;
  logic [7:0]  status;
  logic [15:0] saddr;

  int checks = 0;
  int errors = 0;
  int ce_mode = 0;     // 0 off, 1 always, 2 random
  bit run_chk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crt_timing uut (
    .clk_i(clk), .rst_ni(rst_ni), .char_en_i(char_en), .we_i(we), .sel_i(sel),
    .wdata_i(wdata), .rdata_o(rdata), .display_en_o(disp), .hblank_o(hblank),
    .vblank_o(vblank), .hsync_o(hsync), .vsync_o(vsync), .status_o(status),
    .start_addr_o(saddr), .split_o(split)
  );

  // reference state
  logic [7:0]  m_regs [32];
  logic [4:0]  m_idx;
  logic [8:0]  m_hc;
  logic [10:0] m_vc;
  logic        m_hb, m_hr, m_vb, m_vr;

  function automatic logic [9:0] f_vtot(); return {m_regs[7][5], m_regs[7][0], m_regs[6]}; endfunction
  function automatic logic [9:0] f_vde();  return {m_regs[7][6], m_regs[7][1], m_regs[18]}; endfunction
  function automatic logic [9:0] f_vss();  return {m_regs[7][7], m_regs[7][2], m_regs[16]}; endfunction
  function automatic logic [9:0] f_vbs();  return {1'b0, m_regs[7][3], m_regs[21]}; endfunction
  function automatic logic [9:0] f_lcmp(); return {1'b0, m_regs[7][4], m_regs[24]}; endfunction
  function automatic logic [5:0] f_hbe();  return {m_regs[5][7], m_regs[3][4:0]}; endfunction
  function automatic logic f_disp();
    return (m_hc <= {1'b0, m_regs[1]}) && (m_vc <= {1'b0, f_vde()});
  endfunction
  function automatic logic f_wr_ok(input logic [4:0] ix);
    return (ix <= 5'd25) && !(m_regs[17][7] && ix <= 5'd7);
  endfunction

  always @(posedge clk) begin
    logic [8:0]  hn;
    logic [10:0] vn;
    logic        lt;
    if (!rst_ni) begin
      m_idx <= '0; m_hc <= '0; m_vc <= '0;
      m_hb <= 0; m_hr <= 0; m_vb <= 0; m_vr <= 0;
      for (int i = 0; i < 32; i++) m_regs[i] <= '0;
    end else begin
      if (char_en) begin
        lt = (m_hc == {1'b0, m_regs[0]} + 9'd4);
        hn = lt ? 9'd0 : m_hc + 9'd1;
        m_hc <= hn;
        if (hn == {1'b0, m_regs[2]}) m_hb <= 1;
        else if (hn[5:0] == f_hbe()) m_hb <= 0;
        if (hn == {1'b0, m_regs[4]}) m_hr <= 1;
        else if (hn[4:0] == m_regs[5][4:0]) m_hr <= 0;
        if (lt) begin
          vn = (m_vc == {1'b0, f_vtot()} + 11'd1) ? 11'd0 : m_vc + 11'd1;
          m_vc <= vn;
          if (vn == {1'b0, f_vbs()}) m_vb <= 1;
          else if (vn[7:0] == m_regs[22]) m_vb <= 0;
          if (vn == {1'b0, f_vss()}) m_vr <= 1;
          else if (vn[3:0] == m_regs[17][3:0]) m_vr <= 0;
        end
      end
      if (we) begin
        if (!sel) m_idx <= wdata[4:0];
        else if (f_wr_ok(m_idx)) m_regs[m_idx] <= wdata;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R1 R2 display_en", 32'(disp), 32'(f_disp()));
    check("R3 hblank", 32'(hblank), 32'(m_hb));
    check("R4 R8 hsync", 32'(hsync), 32'(m_hr ^ m_regs[25][6]));
    check("R5 R6 vblank", 32'(vblank), 32'(m_vb));
    check("R7 R8 vsync", 32'(vsync), 32'(m_vr ^ m_regs[25][7]));
    check("R4 R7 status", 32'(status), 32'({4'b0, m_vr, 2'b0, ~f_disp()}));
    check("R10 split", 32'(split), 32'(m_vc == {1'b0, f_lcmp()}));
    check("R11 start_addr", 32'(saddr), 32'({m_regs[12], m_regs[13]}));
  endtask

  always @(negedge clk) begin
    if (run_chk) compare_all();
    case (ce_mode)
      1:       char_en <= 1'b1;
      2:       char_en <= ($urandom % 4) != 0;
      default: char_en <= 1'b0;
    endcase
  end

  task automatic bus_wr(input logic s, input logic [7:0] d);
    @(negedge clk); we = 1; sel = s; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic wreg(input logic [4:0] ix, input logic [7:0] d);
    bus_wr(0, {3'b0, ix});
    bus_wr(1, d);
  endtask

  task automatic rd_check(input string tag, input logic s, input logic [7:0] exp);
    @(negedge clk); sel = s; we = 0;
    #1 check(tag, 32'(rdata), 32'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1994));
    idle(3);
    @(negedge clk) rst_ni = 1;
    #1;
    // R12 reset state: all zero registers give a lit first character
    check("R12 reset display_en", 32'(disp), 32'd1);
    check("R12 reset flags", 32'({hblank, vblank, hsync, vsync}), 32'd0);
    check("R12 reset status", 32'(status), 32'd0);
    check("R12 reset split", 32'(split), 32'd1);
    check("R12 reset start_addr", 32'(saddr), 32'd0);
    rd_check("R12 R13 reset index", 0, 8'd0);
    run_chk = 1;

    // config A: 16 chars x 12 lines
    wreg(0, 11); wreg(1, 9); wreg(2, 10); wreg(3, 15); wreg(4, 12); wreg(5, 14);
    wreg(6, 10); wreg(7, 0); wreg(16, 9); wreg(17, 10); wreg(18, 7);
    wreg(21, 8); wreg(22, 11); wreg(24, 4); wreg(12, 8'h12); wreg(13, 8'h34);
    rd_check("R13 index readback", 0, 8'd13);
    rd_check("R13 data readback", 1, 8'h34);
    ce_mode = 1; idle(600);
    ce_mode = 2; idle(1500);
    ce_mode = 0; idle(30);           // R1 counting halts without enable
    ce_mode = 2;

    // config B: bit 8 of vertical fields from overflow, inverted syncs
    wreg(7, 8'h1F); wreg(6, 44); wreg(18, 3); wreg(16, 34); wreg(21, 24);
    wreg(22, 30); wreg(17, 3); wreg(24, 4); wreg(25, 8'hC0);
    ce_mode = 1; idle(5200);
    ce_mode = 2; idle(3000);

    // config C: bit 9 of display end and retrace start
    wreg(7, 8'hC0); wreg(18, 0); wreg(16, 0); wreg(25, 8'h40);
    idle(2500);

    // R9 write protection
    wreg(17, 8'h8A);
    wreg(0, 8'h55);
    rd_check("R9 protected htotal", 1, 8'd11);
    wreg(7, 8'hFF);
    rd_check("R9 protected overflow", 1, 8'hC0);
    wreg(13, 8'h77);
    rd_check("R9 unprotected index", 1, 8'h77);
    wreg(17, 8'h0A);
    wreg(0, 8'h0F);
    rd_check("R9 unprotected htotal", 1, 8'h0F);
    wreg(29, 8'hAB);
    rd_check("R9 R13 index above range", 1, 8'h00);
    idle(800);

    // random phase
    for (int it = 0; it < 120; it++) begin
      logic [4:0] ix;
      logic [7:0] d;
      logic [7:0] exp;
      ix = 5'($urandom % 32);
      d  = 8'($urandom);
      if (ix == 0 || ix == 6) d = d & 8'h1F;   // keep frames short
      if (ix == 7) d = d & 8'h1F;
      exp = f_wr_ok(ix) ? d : m_regs[ix];
      wreg(ix, d);
      rd_check("R9 R13 random readback", 1, exp);
      idle(50 + ($urandom % 150));
    end

    run_chk = 0;
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule